// File: doc/BRIEF.md
# PCM Voice Codec Serial Port

This block links a parallel voice datapath to an external linear codec over a four-wire serial PCM connection, carrying data in both directions at once. A frame holds two 16-bit slots. In each slot a 13-bit two's-complement sample sits in the upper bit positions and is sent MSB first. The three low bits of each transmitted slot are filled by a rule picked at the pins. The receiver ignores those three bits.

As clock master, the port divides the system clock to make the bit clock and drives a one-bit-wide frame sync. The division ratio follows a wideband input: narrowband gives 8 kHz frames, and wideband gives 16 kHz frames. As slave, the port follows an external bit clock and frame sync. It resynchronises both into the system clock and acts on their edges.

On the parallel side, a transmit sample is written into a one-entry holding register and is used at the start of the next slot. Each received sample comes out with a one-cycle strobe and the index of its slot.

Top module: `pcm_voice_port`

## Requirements
- R1: Each transmitted slot is 16 bits, MSB first. Slot bits 15..3 carry the 13-bit sample. The first bit of a slot is driven at the bit-clock fall that comes before it, and every later bit changes only on a falling bit-clock edge.
- R2: The three low slot bits follow `fill_mode`, latched at slot start: 0 gives 000, 1 gives 111, 2 gives three copies of sample bit 12, and 3 gives `fill_pattern`.
- R3: Received data is sampled on rising bit-clock edges. After the 13th bit of a slot, `rx_sample` holds those 13 bits (first bit as bit 12) and `rx_valid` is high for exactly one cycle. `rx_slot` is 0 for the first slot of the frame and 1 for the second. The three low slot bits have no effect on `rx_sample`.
- R4: In master mode, `pcm_fs_o` is high for exactly one bit-clock period, covering the first bit of a frame. It recurs every 32 bit clocks and rises together with a falling bit-clock edge.
- R5: In master mode, the bit clock stays at each level for `NB_HALF` system cycles when `wideband` is 0, and for `WB_HALF` cycles when it is 1.
- R6: A change of `wideband` takes effect only at the start of the next frame. The bits left in the current frame keep the old rate.
- R7: If no sample is held when a slot starts, the slot carries sample value zero with spare bits per R2, and `tx_underrun` goes high and stays high until reset.
- R8: In slave mode, the slot timing follows `pcm_clk_i` and `pcm_fs_i` (frame start is the rising edge that sees the sync high), and `pcm_clk_o` and `pcm_fs_o` stay low.
- R9: After reset in master mode, `pcm_clk_o` is high, and `pcm_fs_o`, `pcm_dout`, `rx_valid` and `tx_underrun` are low. The first bit-clock edge is a fall that starts slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: generate bit clock and sync; 0: follow external ones |
| wideband | input | 1 | 1: 16 kHz frames; 0: 8 kHz frames (master only) |
| fill_mode | input | 2 | Spare-bit rule for transmit slots |
| fill_pattern | input | 3 | Spare bits used when `fill_mode` is 3 |
| tx_sample | input | 13 | Transmit sample, two's complement |
| tx_valid | input | 1 | Writes `tx_sample` into the holding register |
| rx_sample | output | 13 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for `rx_sample` |
| rx_slot | output | 1 | Slot index of `rx_sample` |
| tx_underrun | output | 1 | Sticky flag: a slot started with no sample held |
| pcm_clk_o | output | 1 | Bit clock out (master) |
| pcm_fs_o | output | 1 | Frame sync out (master) |
| pcm_clk_i | input | 1 | Bit clock in (slave) |
| pcm_fs_i | input | 1 | Frame sync in (slave) |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_din | input | 1 | Serial receive data |

## Verification
The properties assume that `master` changes only while reset is held and that `WB_HALF` is at least two. They also assume that an external bit clock holds each level for well over the three-cycle synchroniser delay, and that at most one sample is written per slot. The bench sets the mode only under reset and uses half periods of 8 and 4 cycles in master mode. In slave mode it drives a 10-cycle half period with the sync changing on the falling edge. It writes one sample per slot shortly after each slot ends, and it loops `pcm_dout` back to `pcm_din` so that each received sample can be compared with what was sent.

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
  parameter int NB_HALF = 48,
  parameter int WB_HALF = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic        wideband,
  input  logic [1:0]  fill_mode,
  input  logic [2:0]  fill_pattern,
  input  logic [12:0] tx_sample,
  input  logic        tx_valid,
  output logic [12:0] rx_sample,
  output logic        rx_valid,
  output logic        rx_slot,
  output logic        tx_underrun,
  output logic        pcm_clk_o,
  output logic        pcm_fs_o,
  input  logic        pcm_clk_i,
  input  logic        pcm_fs_i,
  output logic        pcm_dout,
  input  logic        pcm_din
);
  localparam int MAXH = (NB_HALF > WB_HALF) ? NB_HALF : WB_HALF;
  localparam int CW = $clog2(MAXH + 1);
  localparam logic [CW-1:0] NB_H = CW'(NB_HALF);
  localparam logic [CW-1:0] WB_H = CW'(WB_HALF);

  logic [CW-1:0] div_cnt, half_cur;
  logic          bclk, fs_r;
  logic [2:0]    ck_s, fs_s;
  logic [4:0]    pos;
  logic [15:0]   tx_word;
  logic [12:0]   tx_hold;
  logic          tx_full;
  logic [11:0]   rx_sr;
  logic [2:0]    spare;

  wire        m_tick  = master && (div_cnt == half_cur - 1'b1);
  wire        rise_ev = master ? (m_tick && !bclk) : (ck_s[1] && !ck_s[2]);
  wire        fall_ev = master ? (m_tick && bclk)  : (!ck_s[1] && ck_s[2]);
  wire        fs_in   = master ? fs_r : fs_s[1];
  wire [4:0]  pos_nxt = fs_in ? 5'd0 : pos + 5'd1;
  wire [4:0]  tx_pos  = pos + 5'd1;
  wire        load    = fall_ev && (tx_pos[3:0] == 4'd0);
  wire [12:0] tx_data = tx_full ? tx_hold : 13'd0;

  always_comb
    case (fill_mode)
      2'd0:    spare = 3'b000;
      2'd1:    spare = 3'b111;
      2'd2:    spare = {3{tx_data[12]}};
      default: spare = fill_pattern;
    endcase

  wire [15:0] slot_word = {tx_data, spare};

  assign pcm_clk_o = master & bclk;
  assign pcm_fs_o  = master & fs_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      half_cur    <= NB_H;
      bclk        <= 1'b1;
      fs_r        <= 1'b0;
      ck_s        <= '0;
      fs_s        <= '0;
      pos         <= 5'd31;
      tx_word     <= '0;
      tx_hold     <= '0;
      tx_full     <= 1'b0;
      rx_sr       <= '0;
      rx_sample   <= '0;
      rx_valid    <= 1'b0;
      rx_slot     <= 1'b0;
      tx_underrun <= 1'b0;
      pcm_dout    <= 1'b0;
    end else begin
      ck_s     <= {ck_s[1:0], pcm_clk_i};
      fs_s     <= {fs_s[1:0], pcm_fs_i};
      rx_valid <= 1'b0;
      if (master) div_cnt <= m_tick ? '0 : div_cnt + 1'b1;
      if (m_tick) bclk <= !bclk;

      if (rise_ev) begin
        pos   <= pos_nxt;
        rx_sr <= {rx_sr[10:0], pcm_din};
        if (pos_nxt[3:0] == 4'd12) begin
          rx_sample <= {rx_sr, pcm_din};
          rx_valid  <= 1'b1;
          rx_slot   <= pos_nxt[4];
        end
      end

      if (fall_ev) begin
        if (load) begin
          tx_word  <= slot_word;
          pcm_dout <= slot_word[15];
          if (!tx_full) tx_underrun <= 1'b1;
        end else begin
          pcm_dout <= tx_word[~tx_pos[3:0]];
        end
        if (master) begin
          fs_r <= (tx_pos == 5'd0);
          if (tx_pos == 5'd0) half_cur <= wideband ? WB_H : NB_H;
        end
      end

      if (load) tx_full <= 1'b0;
      if (tx_valid) begin
        tx_hold <= tx_sample;
        tx_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic rx_valid,
  input logic tx_underrun,
  input logic pcm_clk_o,
  input logic pcm_fs_o,
  input logic pcm_dout
);
  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(pcm_dout)) |-> $fell(pcm_clk_o)); // R1
  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_SYNC_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $rose(pcm_fs_o)) |-> $fell(pcm_clk_o)); // R4
  AST_CLK_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(pcm_clk_o)) |=> $stable(pcm_clk_o)); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun); // R7
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .rx_valid(rx_valid),
  .tx_underrun(tx_underrun), .pcm_clk_o(pcm_clk_o), .pcm_fs_o(pcm_fs_o),
  .pcm_dout(pcm_dout)
);

// File: tb/sim_pcm_voice_port.sv
`timescale 1ns/1ps
module sim_pcm_voice_port;
  localparam int NBH = 8;
  localparam int WBH = 4;
  localparam int EXH = 10;
  localparam logic [17:0] VEC [8] = '{
    {13'h1555, 2'd0, 3'b000}, {13'h0AAA, 2'd1, 3'b000},
    {13'h1000, 2'd2, 3'b000}, {13'h0FFF, 2'd2, 3'b000},
    {13'h0123, 2'd3, 3'b101}, {13'h1FFF, 2'd3, 3'b010},
    {13'h0001, 2'd1, 3'b000}, {13'h0000, 2'd2, 3'b111}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, master = 1'b1, wideband = 1'b0, tx_valid = 1'b0;
  logic [1:0] fill_mode = 2'd0;
  logic [2:0] fill_pattern = 3'd0;
  logic [12:0] tx_sample = '0;
  logic [12:0] rx_sample;
  logic rx_valid, rx_slot, tx_underrun, pcm_clk_o, pcm_fs_o, pcm_dout;
  logic ext_clk = 1'b0, ext_fs = 1'b0, ext_run = 1'b0;

  pcm_voice_port #(.NB_HALF(NBH), .WB_HALF(WBH)) u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .wideband(wideband),
    .fill_mode(fill_mode), .fill_pattern(fill_pattern),
    .tx_sample(tx_sample), .tx_valid(tx_valid),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .tx_underrun(tx_underrun), .pcm_clk_o(pcm_clk_o), .pcm_fs_o(pcm_fs_o),
    .pcm_clk_i(ext_clk), .pcm_fs_i(ext_fs), .pcm_dout(pcm_dout), .pcm_din(pcm_dout));

  int checks = 0, fails = 0;
  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_up();
  end

  wire mon_clk = master ? pcm_clk_o : ext_clk;
  wire mon_fs  = master ? pcm_fs_o  : ext_fs;
  int bitpos = 31, fs_gap = 0, last_gap = 0, fs_double = 0;
  bit mon_en = 0, fs_prev = 0, cap_slot = 0;
  logic [15:0] sh = '0, cap_word = '0;
  realtime last_t = 0.0;
  realtime per [32];
  event slot_done;

  always @(posedge mon_clk) if (mon_en) begin
    int bp;
    bp = mon_fs ? 0 : (bitpos + 1) % 32;
    if (mon_fs) begin last_gap = fs_gap; fs_gap = 1; end
    else fs_gap++;
    if (mon_fs && fs_prev) fs_double++;
    fs_prev = mon_fs;
    per[bp] = $realtime - last_t;
    last_t = $realtime;
    sh = {sh[14:0], pcm_dout};
    bitpos = bp;
    if (bp % 16 == 15) begin
      cap_word = sh;
      cap_slot = (bp >= 16);
      -> slot_done;
    end
  end

  logic [12:0] rx_last = '0;
  logic rx_slot_last = 1'b0;
  always @(negedge clk) if (rx_valid) begin
    rx_last = rx_sample;
    rx_slot_last = rx_slot;
  end

  initial begin
    forever begin
      if (!ext_run) @(negedge clk);
      else for (int b = 0; b < 32; b++) begin
        ext_clk = 1'b0; ext_fs = (b == 0);
        repeat (EXH) @(negedge clk);
        ext_clk = 1'b1;
        repeat (EXH) @(negedge clk);
      end
    end
  end

  function automatic logic [15:0] expw(logic [12:0] s, logic [1:0] m, logic [2:0] p);
    case (m)
      2'd0: return {s, 3'b000};
      2'd1: return {s, 3'b111};
      2'd2: return {s, {3{s[12]}}};
      default: return {s, p};
    endcase
  endfunction

  logic [15:0] exp_prev = '0;
  logic [12:0] samp_prev = '0;
  bit has_prev = 0;

  task automatic step(bit wr, logic [17:0] v, string req);
    @(slot_done);
    @(negedge clk);
    if (has_prev) begin
      chk(req, "slot word", cap_word, exp_prev);
      chk("R3", "rx sample", rx_last, samp_prev);
      chk("R3", "rx slot index", rx_slot_last, cap_slot);
    end
    fill_mode = v[4:3];
    fill_pattern = v[2:0];
    if (wr) begin tx_sample = v[17:5]; tx_valid = 1'b1; end
    exp_prev = expw(wr ? v[17:5] : 13'd0, v[4:3], v[2:0]);
    samp_prev = wr ? v[17:5] : 13'd0;
    has_prev = 1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic do_reset(bit m);
    rst_n = 1'b0; master = m; wideband = 1'b0; tx_valid = 1'b0;
    fill_mode = 2'd0; fill_pattern = 3'd0; mon_en = 0;
    repeat (4) @(negedge clk);
    bitpos = 31; fs_gap = 0; fs_prev = 0; fs_double = 0;
    last_t = $realtime; mon_en = 1;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    chk("R9", "reset clk", pcm_clk_o, 1);
    chk("R9", "reset sync", pcm_fs_o, 0);
    chk("R9", "reset dout", pcm_dout, 0);
    chk("R9", "reset rx_valid", rx_valid, 0);
    chk("R9", "reset underrun", tx_underrun, 0);

    has_prev = 1; exp_prev = 16'h0000; samp_prev = 13'd0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, VEC[i], "R2");
      if (i == 0) chk("R7", "underrun after empty slot 0", tx_underrun, 1);
    end
    chk("R5", "narrowband bit period x10", $rtoi(per[5] * 10.0), 2 * NBH * 50);
    chk("R4", "sync spacing in bit clocks", last_gap, 32);
    chk("R4", "sync wider than one bit", fs_double, 0);

    step(1'b0, {13'h0ABC, 2'd1, 3'd0}, "R2");
    step(1'b1, VEC[4], "R7");
    chk("R7", "underrun stays set", tx_underrun, 1);

    while (cap_slot != 1'b0) step(1'b1, VEC[5], "R1");
    wideband = 1'b1;
    step(1'b1, VEC[6], "R1");
    chk("R6", "old rate to frame end x10", $rtoi(per[31] * 10.0), 2 * NBH * 50);
    step(1'b1, VEC[2], "R1");
    chk("R5", "wideband bit period x10", $rtoi(per[1] * 10.0), 2 * WBH * 50);
    chk("R6", "new rate within new frame x10", $rtoi(per[15] * 10.0), 2 * WBH * 50);
    step(1'b1, VEC[3], "R1");
    step(1'b1, VEC[1], "R1");
    chk("R4", "wideband sync spacing", last_gap, 32);

    do_reset(1'b0);
    ext_run = 1'b1;
    has_prev = 0;
    step(1'b1, VEC[2], "R8");
    for (int i = 3; i < 8; i++) step(1'b1, VEC[i], "R8");
    step(1'b1, VEC[0], "R8");
    chk("R8", "bit period follows input x10", $rtoi(per[5] * 10.0), 2 * EXH * 50);
    chk("R8", "clock out low in slave", pcm_clk_o, 0);
    chk("R8", "sync out low in slave", pcm_fs_o, 0);
    finish_up();
  end
endmodule